// File: doc/BRIEF.md
# Group-Testing Fault Isolation Controller

The controller finds which slice of a pool of suspect resources holds a single stuck-at fault. The pool is split into equal subgroups. A population of test configurations ("individuals") each uses a chosen set of subgroups. An outside agent loads the configuration the controller names, runs duplicated copies of the logic on it, and returns one bit that says whether the two copies' outputs disagreed. The controller keeps the suspect set as a per-resource bitmask and narrows it from these answers.

There are two allocation modes. In equal-share mode each individual owns one subgroup, and the first individual that shows a disagreement ends the search. In interleaved mode each subgroup is shared by a coverage factor of individuals, so the fault is less likely to go unseen. Pass one stops at the first disagreeing individual and leaves its wider coverage as the suspect set. Pass two then queries only the individuals whose coverage overlaps it. Each of their answers keeps or removes their coverage from the suspect set, which brings the result down to one subgroup. When no individual disagrees, the fault is reported as unarticulated and the mask stays full.

Top module: `cgt_isolator`

## Requirements
- R1: After reset, `test_req` and `done` are low, `status` is 00 and `suspect_mask` is all ones.
- R2: `start` is taken only when the controller is idle. A `start` raised during a run, or in the cycle `done` is high, has no effect: the request sequence and the result stay unchanged, and no new request follows.
- R3: `test_req` stays high with a stable `test_idx` until a cycle with `test_ack` high. Each such cycle consumes exactly one answer, taken from `test_disc`. `test_ack` and `test_disc` have no effect while `test_req` is low.
- R4: Resource r belongs to subgroup r / 8. Individual i covers subgroups i, i+1, …, i+CF−1 modulo 8. With `mode_interleave` = 0, CF is 1 whatever `cf_sel` holds. With `mode_interleave` = 1, `cf_sel` 00 gives CF 1, 01 gives CF 2, and 10 or 11 gives CF 4. Mode and CF are captured when `start` is taken.
- R5: Pass one requests individuals 0, 1, 2, … in ascending order and stops at the first answer with `test_disc` = 1. With CF = 1 the run then ends, with the mask equal to that individual's subgroup and status isolated.
- R6: Pass two (CF > 1) requests, in ascending order, every individual j other than the pass-one hit h whose covered subgroups overlap those of h, and no other individual.
- R7: At the end of pass one the mask becomes the hit's coverage. In pass two, a disagreeing answer ANDs the mask with that individual's coverage, and an agreeing answer ANDs it with the complement. The mask never gains bits during a run.
- R8: If all 8 pass-one answers agree, exactly 8 requests are made, `status` is 10 (unarticulated) and the mask is all ones.
- R9: At the end of pass two, `status` is 01 (isolated) when the mask equals exactly one full subgroup, and 11 (ambiguous) otherwise, for example when the mask is empty.
- R10: `done` is high for exactly one cycle, in the cycle after the final answer is taken (pass two: after the final scan), with `test_req` low. `status` and `suspect_mask` are valid then and hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an isolation run (taken only when idle) |
| mode_interleave | input | 1 | 0 = equal-share, 1 = interleaved |
| cf_sel | input | 2 | Coverage factor select in interleaved mode |
| test_req | output | 1 | Request: test the individual on `test_idx` |
| test_idx | output | 3 | Index of the individual to test |
| test_ack | input | 1 | Answer strobe for the pending request |
| test_disc | input | 1 | Duplex outputs disagreed for this individual |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 none, 01 isolated, 10 unarticulated, 11 ambiguous |
| suspect_mask | output | 64 | Per-resource suspect bitmask |

## Verification
Two pairs of events can fall in the same cycle. In the first, an answer arrives in the same cycle a request is raised: the zero-latency responder acknowledges at the first clock edge where `test_req` is high. The index order and the final mask must still match the bench's own model. In the second, a new `start` arrives in the cycle `done` pulses: the bench raises `start` exactly while `done` is high, then confirms that no request appears and that the result registers keep their values. A `start` raised in the middle of a run must likewise leave the request sequence unchanged.

// File: rtl/cgt_pkg.sv
package cgt_pkg;

  typedef enum logic [1:0] {
    CGT_NONE     = 2'b00,
    CGT_ISOLATED = 2'b01,
    CGT_UNART    = 2'b10,
    CGT_AMBIG    = 2'b11
  } cgt_status_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROBE,
    ST_SCAN,
    ST_FIN
  } cgt_state_e;

endpackage

// File: rtl/cgt_cover_gen.sv
// Subgroup coverage of one individual: subgroup g is covered when
// (g - idx) mod R lies below the coverage factor.
module cgt_cover_gen #(
  parameter int R_IND  = 8,
  parameter int CF_MAX = 4,
  localparam int IDX_W = $clog2(R_IND),
  localparam int CF_W  = $clog2(CF_MAX) + 1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [CF_W-1:0]  cf,
  output logic [R_IND-1:0] grp
);

  function automatic logic covers(input logic [IDX_W-1:0] g,
                                  input logic [IDX_W-1:0] i,
                                  input logic [CF_W-1:0]  c);
    logic [IDX_W-1:0] off;
    off = g - i;
    return (int'(off) < int'(c));
  endfunction

  for (genvar g = 0; g < R_IND; g++) begin : g_grp
    assign grp[g] = covers(IDX_W'(g), idx, cf);
  end

endmodule

// File: rtl/cgt_mask_expand.sv
// Widen a subgroup mask to a per-resource mask.
module cgt_mask_expand #(
  parameter int R_IND = 8,
  parameter int M_SUB = 8
) (
  input  logic [R_IND-1:0]       grp,
  output logic [R_IND*M_SUB-1:0] res
);

  for (genvar g = 0; g < R_IND; g++) begin : g_sub
    assign res[g*M_SUB +: M_SUB] = {M_SUB{grp[g]}};
  end

endmodule

// File: rtl/cgt_result_judge.sv
// Isolated when the mask is exactly one whole subgroup, else ambiguous.
module cgt_result_judge #(
  parameter int R_IND = 8,
  parameter int M_SUB = 8
) (
  input  logic [R_IND*M_SUB-1:0] mask,
  output cgt_pkg::cgt_status_e   verdict
);
  import cgt_pkg::*;

  logic [R_IND-1:0] full_g;
  logic [R_IND-1:0] part_g;

  for (genvar g = 0; g < R_IND; g++) begin : g_chk
    assign full_g[g] = &mask[g*M_SUB +: M_SUB];
    assign part_g[g] = (|mask[g*M_SUB +: M_SUB]) & ~full_g[g];
  end

  function automatic int count_set(input logic [R_IND-1:0] v);
    int n;
    n = 0;
    for (int k = 0; k < R_IND; k++) n += int'(v[k]);
    return n;
  endfunction

  assign verdict = ((count_set(full_g) == 1) && (part_g == '0)) ? CGT_ISOLATED
                                                                 : CGT_AMBIG;

endmodule

// File: rtl/cgt_isolator.sv
module cgt_isolator #(
  parameter int N_RES  = 64,
  parameter int R_IND  = 8,
  parameter int CF_MAX = 4,
  localparam int IDX_W = $clog2(R_IND),
  localparam int CNT_W = IDX_W + 1,
  localparam int CF_W  = $clog2(CF_MAX) + 1,
  localparam int M_SUB = N_RES / R_IND
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_interleave,
  input  logic [1:0]       cf_sel,
  output logic             test_req,
  output logic [IDX_W-1:0] test_idx,
  input  logic             test_ack,
  input  logic             test_disc,
  output logic             done,
  output logic [1:0]       status,
  output logic [N_RES-1:0] suspect_mask
);
  import cgt_pkg::*;

  function automatic logic [CF_W-1:0] cf_decode(input logic md,
                                               input logic [1:0] sel);
    int v;
    if (!md)              v = 1;
    else if (sel == 2'b00) v = 1;
    else if (sel == 2'b01) v = 2;
    else                   v = 4;
    if (v > CF_MAX) v = CF_MAX;
    return CF_W'(v);
  endfunction

  cgt_state_e          state_q;
  logic [CNT_W-1:0]    cur_q;
  logic [IDX_W-1:0]    hit_q;
  logic [CF_W-1:0]     cf_q;
  logic                pass2_q;
  logic [N_RES-1:0]    suspect_q;
  cgt_status_e         status_q;

  logic [R_IND-1:0]    grp_cur, grp_hit;
  logic [N_RES-1:0]    res_cur;
  cgt_status_e         verdict;

  // named internal events
  logic run_idle, accept_start, ack_fire, hit_fire, scan_end, is_partner;

  cgt_cover_gen #(.R_IND(R_IND), .CF_MAX(CF_MAX)) u_cov_cur (
    .idx(cur_q[IDX_W-1:0]), .cf(cf_q), .grp(grp_cur));

  cgt_cover_gen #(.R_IND(R_IND), .CF_MAX(CF_MAX)) u_cov_hit (
    .idx(hit_q), .cf(cf_q), .grp(grp_hit));

  cgt_mask_expand #(.R_IND(R_IND), .M_SUB(M_SUB)) u_expand (
    .grp(grp_cur), .res(res_cur));

  cgt_result_judge #(.R_IND(R_IND), .M_SUB(M_SUB)) u_judge (
    .mask(suspect_q), .verdict(verdict));

  assign run_idle     = (state_q == ST_IDLE);
  assign accept_start = run_idle && start;
  assign ack_fire     = (state_q == ST_PROBE) && test_ack;
  assign hit_fire     = ack_fire && !pass2_q && test_disc;
  assign scan_end     = (state_q == ST_SCAN) && (cur_q == CNT_W'(R_IND));
  assign is_partner   = (cur_q[IDX_W-1:0] != hit_q) && (|(grp_cur & grp_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      hit_q     <= '0;
      cf_q      <= CF_W'(1);
      pass2_q   <= 1'b0;
      suspect_q <= '1;
      status_q  <= CGT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_start) begin
            cf_q      <= cf_decode(mode_interleave, cf_sel);
            suspect_q <= '1;
            status_q  <= CGT_NONE;
            cur_q     <= '0;
            pass2_q   <= 1'b0;
            state_q   <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (ack_fire) begin
            if (!pass2_q) begin
              if (hit_fire) begin
                hit_q     <= cur_q[IDX_W-1:0];
                suspect_q <= res_cur;
                if (cf_q == CF_W'(1)) begin
                  status_q <= CGT_ISOLATED;
                  state_q  <= ST_FIN;
                end else begin
                  pass2_q <= 1'b1;
                  cur_q   <= '0;
                  state_q <= ST_SCAN;
                end
              end else if (cur_q == CNT_W'(R_IND - 1)) begin
                status_q <= CGT_UNART;
                state_q  <= ST_FIN;
              end else begin
                cur_q <= cur_q + 1'b1;
              end
            end else begin
              suspect_q <= test_disc ? (suspect_q & res_cur)
                                     : (suspect_q & ~res_cur);
              cur_q     <= cur_q + 1'b1;
              state_q   <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (scan_end) begin
            status_q <= verdict;
            state_q  <= ST_FIN;
          end else if (is_partner) begin
            state_q <= ST_PROBE;
          end else begin
            cur_q <= cur_q + 1'b1;
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign test_req     = (state_q == ST_PROBE);
  assign test_idx     = cur_q[IDX_W-1:0];
  assign done         = (state_q == ST_FIN);
  assign status       = status_q;
  assign suspect_mask = suspect_q;

endmodule

// File: rtl/cgt_isolator_chk.sv
module cgt_isolator_chk #(
  parameter int N_RES = 64,
  parameter int R_IND = 8,
  localparam int IDX_W = $clog2(R_IND),
  localparam int M_SUB = N_RES / R_IND
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_req,
  input logic [IDX_W-1:0] test_idx,
  input logic             test_ack,
  input logic             done,
  input logic [1:0]       status,
  input logic [N_RES-1:0] suspect_mask,
  input logic             accept_start
);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && !test_ack |=> test_req && $stable(test_idx));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !test_req);

  p_start_issues_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> test_req && (test_idx == '0));

  p_status_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status != 2'b00);

  p_unart_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status == 2'b10) |-> (&suspect_mask));

  p_iso_one_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && (status == 2'b01) |-> ($countones(suspect_mask) == M_SUB));

  p_no_growth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_start |=> ((suspect_mask & ~$past(suspect_mask)) == '0));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(status) && $stable(suspect_mask));

endmodule

bind cgt_isolator cgt_isolator_chk #(.N_RES(N_RES), .R_IND(R_IND)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_req(test_req), .test_idx(test_idx),
  .test_ack(test_ack), .done(done), .status(status),
  .suspect_mask(suspect_mask), .accept_start(accept_start));

// File: tb/cgt_isolator_bench.sv
module cgt_isolator_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode_interleave = 1'b0;
  logic [1:0]  cf_sel = 2'b00;
  logic        test_req;
  logic [2:0]  test_idx;
  logic        test_ack = 1'b0;
  logic        test_disc = 1'b0;
  logic        done;
  logic [1:0]  status;
  logic [63:0] suspect_mask;

  int n_chk = 0;
  int n_bad = 0;
  int exp_seq[16];
  int got_seq[16];
  int n_exp;
  logic [63:0] exp_mask;
  logic [1:0]  exp_st;

  always #4 clk = ~clk;

  cgt_isolator u_cgt_isolator (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_interleave(mode_interleave),
    .cf_sel(cf_sel), .test_req(test_req), .test_idx(test_idx),
    .test_ack(test_ack), .test_disc(test_disc), .done(done),
    .status(status), .suspect_mask(suspect_mask));

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // membership: subgroup g is used by individual i when (g-i) mod 8 < cf
  function automatic bit uses(int i, int g, int cf);
    return ((g - i + 8) % 8) < cf;
  endfunction

  function automatic logic [7:0] groups_of(int i, int cf);
    logic [7:0] v = '0;
    for (int g = 0; g < 8; g++) v[g] = uses(i, g, cf);
    return v;
  endfunction

  function automatic logic [63:0] widen(logic [7:0] gs);
    logic [63:0] v = '0;
    for (int r = 0; r < 64; r++) v[r] = gs[r / 8];
    return v;
  endfunction

  function automatic logic [7:0] answers_for(int fault_g, int cf);
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++) v[i] = (fault_g >= 0) && uses(i, fault_g, cf);
    return v;
  endfunction

  task automatic predict(input int cf, input logic [7:0] ans);
    int hit = -1;
    logic [7:0] gs;
    n_exp = 0;
    for (int i = 0; i < 8; i++) begin
      if (hit < 0) begin
        exp_seq[n_exp++] = i;
        if (ans[i]) hit = i;
      end
    end
    if (hit < 0) begin
      exp_st = 2'b10; gs = 8'hFF;
    end else begin
      gs = groups_of(hit, cf);
      if (cf > 1) begin
        for (int j = 0; j < 8; j++) begin
          if (j != hit && ((groups_of(j, cf) & groups_of(hit, cf)) != 0)) begin
            exp_seq[n_exp++] = j;
            gs = ans[j] ? (gs & groups_of(j, cf)) : (gs & ~groups_of(j, cf));
          end
        end
        exp_st = ($countones(gs) == 1) ? 2'b01 : 2'b11;
      end else begin
        exp_st = 2'b01;
      end
    end
    exp_mask = widen(gs);
  endtask

  // one run: poke_mid raises start during the run, collide raises it with done
  task automatic run_case(input string rq, input bit md, input logic [1:0] sel,
                          input int cf_eff, input logic [7:0] ans, input int lat,
                          input bit poke_mid, input bit collide);
    int got = 0;
    int wcnt = 0;
    int cyc = 0;
    bit seen = 0;
    bit req_at_done = 0;
    predict(cf_eff, ans);
    @(negedge clk);
    start = 1'b1; mode_interleave = md; cf_sel = sel;
    @(negedge clk);
    start = 1'b0; mode_interleave = ~md; cf_sel = ~sel;
    while (!seen && cyc < 400) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      start = 1'b0;
      test_ack = 1'b0;
      test_disc = 1'b1;
      if (done) begin
        seen = 1;
        req_at_done = test_req;
        if (collide) start = 1'b1;
      end else if (test_req) begin
        if (wcnt < lat) wcnt++;
        else begin
          if (got < 16) got_seq[got] = test_idx;
          got++;
          test_ack = 1'b1;
          test_disc = ans[test_idx];
          wcnt = 0;
          if (poke_mid && got == 2) start = 1'b1;
        end
      end
    end
    check(seen, "R10", {rq, " done seen"}, seen, 1);
    check(!req_at_done, "R10", {rq, " req low at done"}, req_at_done, 0);
    check(got == n_exp, rq, "request count", got, n_exp);
    for (int k = 0; k < n_exp && k < got; k++)
      check(got_seq[k] == exp_seq[k], rq, $sformatf("request %0d index", k),
            got_seq[k], exp_seq[k]);
    check(status == exp_st, rq, "status", status, exp_st);
    check(suspect_mask == exp_mask, rq, "suspect mask", suspect_mask, exp_mask);
    @(negedge clk);
    start = 1'b0;
    test_disc = 1'b0;
    check(!done, "R10", {rq, " done one cycle"}, done, 0);
    check(status == exp_st && suspect_mask == exp_mask, "R10",
          {rq, " result held"}, suspect_mask, exp_mask);
    if (collide) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(!test_req && !done, "R2", "start with done ignored",
              {test_req, done}, 0);
      end
    end
  endtask

  task automatic t_reset;
    check(!test_req, "R1", "reset test_req", test_req, 0);
    check(!done, "R1", "reset done", done, 0);
    check(status == 2'b00, "R1", "reset status", status, 0);
    check(&suspect_mask, "R1", "reset mask", suspect_mask, {64{1'b1}});
  endtask

  task automatic t_stray_ack;
    logic [1:0]  st0 = status;
    logic [63:0] m0 = suspect_mask;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      test_ack = 1'b1; test_disc = 1'b1;
    end
    @(negedge clk);
    test_ack = 1'b0; test_disc = 1'b0;
    check(!test_req && !done, "R3", "ack while idle ignored", {test_req, done}, 0);
    check(status == st0 && suspect_mask == m0, "R3", "idle ack leaves result",
          suspect_mask, m0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R4 R5 equal-share, fault in subgroup 5
    run_case("R5", 1'b0, 2'b00, 1, answers_for(5, 1), 0, 0, 0);
    // R4 equal-share ignores cf_sel
    run_case("R4", 1'b0, 2'b10, 1, answers_for(2, 1), 1, 0, 0);
    // R6 R7 interleaved CF 2, fault 3
    run_case("R6", 1'b1, 2'b01, 2, answers_for(3, 2), 2, 0, 0);
    // R6 wrap: CF 2, fault 0 (individual 7 wraps onto subgroup 0)
    run_case("R6", 1'b1, 2'b01, 2, answers_for(0, 2), 0, 0, 0);
    // R7 CF 4, fault 3 and fault 6, cf_sel 11 also gives 4
    run_case("R7", 1'b1, 2'b10, 4, answers_for(3, 4), 0, 0, 0);
    run_case("R4", 1'b1, 2'b11, 4, answers_for(6, 4), 1, 0, 0);
    // R4 interleaved with cf_sel 00 is CF 1
    run_case("R4", 1'b1, 2'b00, 1, answers_for(7, 1), 0, 0, 0);
    // R8 unarticulated
    run_case("R8", 1'b1, 2'b01, 2, answers_for(-1, 2), 1, 0, 0);
    // R9 ambiguous: only individual 2 disagrees under CF 2 -> empty mask
    run_case("R9", 1'b1, 2'b01, 2, 8'b0000_0100, 0, 0, 0);
    // R2 start during a run, and start coinciding with done
    run_case("R2", 1'b1, 2'b10, 4, answers_for(1, 4), 0, 1, 0);
    run_case("R2", 1'b1, 2'b01, 2, answers_for(4, 2), 1, 0, 1);
    // R3 stray acknowledgements while idle
    t_stray_ack();
    run_case("R3", 1'b1, 2'b01, 2, answers_for(6, 2), 0, 0, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule